// File: doc/BRIEF.md
# Upper Memory Shadow Access Decoder

This block decides, for each memory access in the upper part of a 1 MB address space, where the access goes. A read can be served from local DRAM or from the external expansion/ROM bus. A write can go into DRAM, go out to the external bus, or be dropped. The space from C0000h to EFFFFh is split into twelve 16 KB segments. Each segment has its own enable bit, gated by an area master enable, and a write-protect bit shared with the other segments of its area. The top 64 KB (F0000h–FFFFFh) is a single BIOS region controlled by one bit. All addresses below C0000h go to DRAM.

Three configuration bytes drive the decode. The first is the BIOS/DE control byte, which holds the BIOS mode bit, the D and E area master enables and the D and E write-protect bits. The second is the DE segment-enable byte, one bit per 16 KB segment from D0000h upwards. The third is the C-area control byte, which holds the C segment enables, the C master enable, the C write-protect bit and a global copy-mode bit. Copy mode lets firmware copy ROM contents into DRAM, because reads still come from the bus while writes land in DRAM.

A request is sampled on a clock edge when `req_valid` is high. The routing result appears on the registered outputs one cycle later, together with `rsp_valid`.

Top module: `shadow_dec_top`

## Requirements
- R1: Any address with bits [19:18] not both 1 (below C0000h) routes as read from DRAM, write to DRAM, no external write (rd_dram=1, wr_dram=1, wr_ext=0).
- R2: In F0000h–FFFFFh with bit 7 of `bios_de_cfg` set, reads go to the external bus and writes go to DRAM (rd_dram=0, wr_dram=1, wr_ext=0).
- R3: In F0000h–FFFFFh with bit 7 of `bios_de_cfg` clear, reads come from DRAM and writes are discarded (rd_dram=1, wr_dram=0, wr_ext=0).
- R4: The C area segment i (i=0..3, base C0000h + i·4000h) is shadowed only when bit 4 and bit i of `c_area_cfg` are both set.
- R5: The D/E segment j (j=0..7, base D0000h + j·4000h) is shadowed only when bit j of `de_seg_en` is set and the area enable is set: bit 6 of `bios_de_cfg` for j<4 (D area), bit 5 for j≥4 (E area).
- R6: Outside copy mode, a shadowed segment reads from DRAM. Its writes go to DRAM unless its area is write-protected, in which case they are discarded. Write protect is bit 5 of `c_area_cfg` for the C area, bit 4 of `bios_de_cfg` for the D area and bit 3 of `bios_de_cfg` for the E area.
- R7: With copy mode (bit 6 of `c_area_cfg`) set, every shadowed segment reads from the external bus and writes into DRAM, regardless of write protect.
- R8: A segment in C0000h–EFFFFh that is not shadowed reads from and writes to the external bus (rd_dram=0, wr_dram=0, wr_ext=1).
- R9: Synchronous active-high reset clears all outputs. `rsp_valid` equals `req_valid` of the previous cycle. The routing outputs update only on a valid request and otherwise hold.
- R10: `wr_dram` and `wr_ext` are never both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 20 | Memory address of the request |
| bios_de_cfg | input | 8 | BIOS mode, D/E area enables, D/E write protect |
| de_seg_en | input | 8 | Per-segment enables for D0000h–EFFFFh |
| c_area_cfg | input | 8 | C segment enables, C master enable, C write protect, copy mode |
| rsp_valid | output | 1 | Routing result valid |
| rd_dram | output | 1 | 1: read served from DRAM, 0: from external bus |
| wr_dram | output | 1 | Write goes into DRAM |
| wr_ext | output | 1 | Write goes to the external bus |

## Verification
A corrupted segment-enable or write-protect flag shows up as a wrong triple at the ports. The error appears on the cycle after a request that touches the affected 16 KB segment, and only under the configurations that make that flag matter. An area mis-decode, for example an off-by-one segment base, flips routing at a segment boundary. The bench therefore sweeps every upper segment and several low ones under many combinations of the relevant configuration bits, and compares each result against a model computed from the requirements. Each wrong value is visible exactly one cycle after the request.

// File: rtl/shadow_dec_pkg.sv
package shadow_dec_pkg;

  typedef enum logic [1:0] {
    AREA_LOW  = 2'd0,
    AREA_SEG  = 2'd1,
    AREA_BIOS = 2'd2
  } area_e;

  typedef struct packed {
    logic rd_dram;
    logic wr_dram;
    logic wr_ext;
  } route_t;

  localparam route_t ROUTE_LOCAL   = '{rd_dram: 1'b1, wr_dram: 1'b1, wr_ext: 1'b0};
  localparam route_t ROUTE_BUS     = '{rd_dram: 1'b0, wr_dram: 1'b0, wr_ext: 1'b1};
  localparam route_t ROUTE_COPY    = '{rd_dram: 1'b0, wr_dram: 1'b1, wr_ext: 1'b0};
  localparam route_t ROUTE_RO_DRAM = '{rd_dram: 1'b1, wr_dram: 1'b0, wr_ext: 1'b0};

endpackage

// File: rtl/shadow_addr_class.sv
module shadow_addr_class
  import shadow_dec_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int SEG_SHIFT  = 14,
  parameter int FIRST_BLK  = 48,
  parameter int BIOS_BLK   = 60,
  parameter int IDX_W      = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output area_e             area,
  output logic [IDX_W-1:0]  seg_idx
);
  localparam int BLK_W = ADDR_W - SEG_SHIFT;

  logic [BLK_W-1:0] blk;
  logic [BLK_W-1:0] rel;

  assign blk = addr[ADDR_W-1:SEG_SHIFT];
  assign rel = blk - BLK_W'(FIRST_BLK);

  always_comb begin
    seg_idx = '0;
    if (blk < BLK_W'(FIRST_BLK)) begin
      area = AREA_LOW;
    end else if (blk >= BLK_W'(BIOS_BLK)) begin
      area = AREA_BIOS;
    end else begin
      area    = AREA_SEG;
      seg_idx = rel[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/shadow_seg_table.sv
module shadow_seg_table #(
  parameter int C_SEGS  = 4,
  parameter int DE_SEGS = 8
) (
  input  logic [7:0]                bios_de_cfg,
  input  logic [7:0]                de_seg_en,
  input  logic [7:0]                c_area_cfg,
  output logic [C_SEGS+DE_SEGS-1:0] seg_on,
  output logic [C_SEGS+DE_SEGS-1:0] seg_wp
);
  localparam int HALF = DE_SEGS / 2;

  // C area: master enable in bit 4, write protect in bit 5
  for (genvar i = 0; i < C_SEGS; i++) begin : g_c
    assign seg_on[i] = c_area_cfg[4] & c_area_cfg[i];
    assign seg_wp[i] = c_area_cfg[5];
  end

  // D half uses enable bit 6 / protect bit 4; E half uses bit 5 / bit 3
  for (genvar j = 0; j < DE_SEGS; j++) begin : g_de
    if (j < HALF) begin : g_d
      assign seg_on[C_SEGS+j] = bios_de_cfg[6] & de_seg_en[j];
      assign seg_wp[C_SEGS+j] = bios_de_cfg[4];
    end else begin : g_e
      assign seg_on[C_SEGS+j] = bios_de_cfg[5] & de_seg_en[j];
      assign seg_wp[C_SEGS+j] = bios_de_cfg[3];
    end
  end
endmodule

// File: rtl/shadow_route.sv
module shadow_route
  import shadow_dec_pkg::*;
#(
  parameter int NSEG  = 12,
  parameter int IDX_W = 4
) (
  input  area_e            area,
  input  logic [IDX_W-1:0] seg_idx,
  input  logic [NSEG-1:0]  seg_on,
  input  logic [NSEG-1:0]  seg_wp,
  input  logic             copy_mode,
  input  logic             bios_from_bus,
  output route_t           route
);
  logic sel_on;
  logic sel_wp;

  always_comb begin
    sel_on = 1'b0;
    sel_wp = 1'b0;
    for (int k = 0; k < NSEG; k++) begin
      if (seg_idx == IDX_W'(k)) begin
        sel_on = seg_on[k];
        sel_wp = seg_wp[k];
      end
    end
  end

  always_comb begin
    unique case (area)
      AREA_LOW:  route = ROUTE_LOCAL;
      AREA_BIOS: route = bios_from_bus ? ROUTE_COPY : ROUTE_RO_DRAM;
      AREA_SEG: begin
        if (!sel_on)       route = ROUTE_BUS;
        else if (copy_mode) route = ROUTE_COPY;
        else if (sel_wp)   route = ROUTE_RO_DRAM;
        else               route = ROUTE_LOCAL;
      end
      default:   route = ROUTE_LOCAL;
    endcase
  end
endmodule

// File: rtl/shadow_dec_top.sv
module shadow_dec_top
  import shadow_dec_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 14,
  parameter int C_SEGS    = 4,
  parameter int DE_SEGS   = 8,
  parameter int BIOS_BLKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        bios_de_cfg,
  input  logic [7:0]        de_seg_en,
  input  logic [7:0]        c_area_cfg,
  output logic              rsp_valid,
  output logic              rd_dram,
  output logic              wr_dram,
  output logic              wr_ext
);
  localparam int NSEG       = C_SEGS + DE_SEGS;
  localparam int TOTAL_BLKS = 2 ** (ADDR_W - SEG_SHIFT);
  localparam int BIOS_BLK   = TOTAL_BLKS - BIOS_BLKS;
  localparam int FIRST_BLK  = BIOS_BLK - NSEG;
  localparam int IDX_W      = $clog2(NSEG);

  area_e            area;
  logic [IDX_W-1:0] seg_idx;
  logic [NSEG-1:0]  seg_on;
  logic [NSEG-1:0]  seg_wp;
  route_t           route;

  shadow_addr_class #(
    .ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT), .FIRST_BLK(FIRST_BLK),
    .BIOS_BLK(BIOS_BLK), .IDX_W(IDX_W)
  ) u_class (
    .addr(req_addr), .area(area), .seg_idx(seg_idx)
  );

  shadow_seg_table #(.C_SEGS(C_SEGS), .DE_SEGS(DE_SEGS)) u_table (
    .bios_de_cfg(bios_de_cfg), .de_seg_en(de_seg_en), .c_area_cfg(c_area_cfg),
    .seg_on(seg_on), .seg_wp(seg_wp)
  );

  shadow_route #(.NSEG(NSEG), .IDX_W(IDX_W)) u_route (
    .area(area), .seg_idx(seg_idx), .seg_on(seg_on), .seg_wp(seg_wp),
    .copy_mode(c_area_cfg[6]), .bios_from_bus(bios_de_cfg[7]), .route(route)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rd_dram   <= 1'b0;
      wr_dram   <= 1'b0;
      wr_ext    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rd_dram <= route.rd_dram;
        wr_dram <= route.wr_dram;
        wr_ext  <= route.wr_ext;
      end
    end
  end

  AST_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(wr_dram && wr_ext)); // R10

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R9

  AST_LOW_TO_DRAM: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_addr[ADDR_W-1:ADDR_W-2] != 2'b11))
      |-> (rd_dram && wr_dram && !wr_ext)); // R1

  AST_BIOS_NO_BUS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_addr[ADDR_W-1:ADDR_W-4] == 4'hF)) |-> !wr_ext); // R2

  AST_BUS_WRITE_BUS_READ: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && wr_ext) |-> !rd_dram); // R8

  AST_COPY_READS_BUS: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(c_area_cfg[6]) &&
     $past(req_addr[ADDR_W-1:ADDR_W-2] == 2'b11) &&
     $past(req_addr[ADDR_W-1:ADDR_W-4] != 4'hF)) |-> !rd_dram); // R7

  AST_C_PROTECT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_addr[ADDR_W-1:ADDR_W-4] == 4'hC) &&
     $past(c_area_cfg[5]) && !$past(c_area_cfg[6])) |-> !wr_dram); // R6

endmodule

// File: tb/tb_shadow_dec_top.sv
module tb_shadow_dec_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [19:0] req_addr;
  logic [7:0]  bios_de_cfg, de_seg_en, c_area_cfg;
  logic        rsp_valid, rd_dram, wr_dram, wr_ext;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  shadow_dec_top dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .bios_de_cfg(bios_de_cfg), .de_seg_en(de_seg_en), .c_area_cfg(c_area_cfg),
    .rsp_valid(rsp_valid), .rd_dram(rd_dram), .wr_dram(wr_dram), .wr_ext(wr_ext)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s addr=%h a=%h b=%h c=%h got=%b exp=%b",
               tag, req_addr, bios_de_cfg, de_seg_en, c_area_cfg, got, exp);
    end
  endtask

  // expected {valid, rd_dram, wr_dram, wr_ext} from the requirements
  task automatic model(input logic [19:0] addr, output logic [3:0] exp, output string tag);
    int blk = int'(addr[19:14]);
    logic sh, wp;
    int i;
    if (blk < 48) begin
      exp = 4'b1110; tag = "R1";
    end else if (blk >= 60) begin
      if (bios_de_cfg[7]) begin exp = 4'b1010; tag = "R2"; end
      else begin exp = 4'b1100; tag = "R3"; end
    end else begin
      if (blk < 52) begin
        i = blk - 48; sh = c_area_cfg[4] & c_area_cfg[i]; wp = c_area_cfg[5]; tag = "R4";
      end else if (blk < 56) begin
        i = blk - 52; sh = bios_de_cfg[6] & de_seg_en[i]; wp = bios_de_cfg[4]; tag = "R5";
      end else begin
        i = blk - 52; sh = bios_de_cfg[5] & de_seg_en[i]; wp = bios_de_cfg[3]; tag = "R5";
      end
      if (!sh) begin exp = 4'b1001; tag = {tag, "/R8"}; end
      else if (c_area_cfg[6]) begin exp = 4'b1010; tag = {tag, "/R7"}; end
      else begin exp = {2'b11, ~wp, 1'b0}; tag = {tag, "/R6"}; end
    end
  endtask

  task automatic run_vec(input logic [19:0] addr);
    logic [3:0] exp;
    string tag;
    req_valid = 1'b1;
    req_addr  = addr;
    model(addr, exp, tag);
    @(posedge clk);
    @(negedge clk);
    check(tag, {rsp_valid, rd_dram, wr_dram, wr_ext}, exp);
    check("R10", {3'b000, wr_dram & wr_ext}, 4'b0000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] bpat [4];
    logic [3:0] cpat [4];
    logic [3:0] held;
    int segs [19];
    bpat = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
    cpat = '{4'h0, 4'hF, 4'h9, 4'h6};
    segs[0] = 0; segs[1] = 20; segs[2] = 47;
    for (int s = 0; s < 16; s++) segs[3+s] = 48 + s;

    rst = 1'b1; req_valid = 1'b0; req_addr = '0;
    bios_de_cfg = 8'h00; de_seg_en = 8'h00; c_area_cfg = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset", {rsp_valid, rd_dram, wr_dram, wr_ext}, 4'b0000);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9 idle", {rsp_valid, rd_dram, wr_dram, wr_ext}, 4'b0000);

    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 4; b++) begin
        for (int cc = 0; cc < 8; cc++) begin
          for (int cl = 0; cl < 4; cl++) begin
            bios_de_cfg = {a[4:0], 3'b101};
            de_seg_en   = bpat[b];
            c_area_cfg  = {1'b0, cc[2:0], cpat[cl]};
            for (int s = 0; s < 19; s++) begin
              int off = (a * 977 + b * 313 + cc * 71 + cl * 29 + s * 1237) & 16'h3FFF;
              run_vec({segs[s][5:0], off[13:0]});
            end
          end
        end
      end
    end

    // R9: outputs hold while no request is presented
    bios_de_cfg = 8'h00; c_area_cfg = 8'h00; de_seg_en = 8'h00;
    run_vec(20'hC4000);
    held = {rsp_valid, rd_dram, wr_dram, wr_ext};
    req_valid = 1'b0;
    req_addr  = 20'h00000;
    @(posedge clk); @(negedge clk);
    check("R9 hold", {rsp_valid, rd_dram, wr_dram, wr_ext}, {1'b0, held[2:0]});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule